// File: doc/BRIEF.md
# Power-Up Reset Time-Out Sequencer

This block keeps a processor core in reset after a power-on event, a brown-out or an external reset. It releases the core only after a chain of delays, each of which may be skipped, has run out. The first delay is a power-up timer. It counts edges of a slow internal RC clock. The second is an oscillator start-up timer that counts edges of the main oscillator, and the third is a PLL-lock wait counted on the RC clock. The supply comparator, the RC oscillator, the main oscillator and the PLL all sit outside the block and reach it only as input pins.

The block runs on one fast sampling clock. The RC and oscillator inputs pass through two-flop synchronisers and an edge detector, which turn them into single-cycle ticks. The power-on pulse works as an asynchronous active-low reset and is released synchronously. The external reset pin takes no part in the time-out chain. It only gates the final release, so every delay can expire while the pin is held low. Three sticky cause flags record why the core was last reset, and software clears them with a single strobe.

Top module: `reset_timeout_seq`

## Requirements
- R1: While `por_n` is low and after it rises, `core_rst_n` is 0, `flag_por` is 1, and `flag_bor` and `flag_ext` are 0.
- R2: When `pwrt_en_n` is 0, the core stays in reset until 2^PWRT_W rising edges of `rc_clk` have been seen after the sequence starts.
- R3: For the crystal mode codes 0 (LP), 1 (XT), 2 (HS) and 3 (HSPLL), a power-on sequence adds OST_CYCLES rising edges of `osc_clk` after the power-up timer. Edges of `osc_clk` that arrive while the power-up timer is running are not counted.
- R4: Mode code 3 adds a further PLL_TICKS rising edges of `rc_clk` after the oscillator start-up count.
- R5: With a non-crystal mode code (4 to 7) and `pwrt_en_n` at 1, `core_rst_n` rises within 8 clock cycles of `por_n` rising, and no edge of `rc_clk` or `osc_clk` is needed.
- R6: With `bor_en` at 1, if `bor_det` stays high for BOR_QUAL or more consecutive clock cycles, the core is forced into reset and `flag_bor` is set. The core then stays in reset for as long as `bor_det` stays high. A shorter pulse, or any pulse while `bor_en` is 0, has no effect.
- R7: After a brown-out ends, the power-up timer runs its full count again if it is enabled, and the core is then released with no oscillator start-up or PLL wait. A brown-out that arrives while the timer is counting restarts the count from zero.
- R8: The delays run to completion while `mclr_n` is low. If `mclr_n` rises after the delays have ended, the core is released within 4 cycles. Pulling `mclr_n` low later resets the core again without rerunning any delay, and sets `flag_ext`.
- R9: The cause flags stay set until `clr_flags` is pulsed, which clears all three. A power-on sets `flag_por` and clears the other two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock for the whole block |
| por_n | input | 1 | Power-on pulse, active low, asynchronous |
| rc_clk | input | 1 | Slow internal RC clock |
| osc_clk | input | 1 | Main oscillator clock |
| bor_det | input | 1 | Raw flag from the supply comparator, high while the supply is low |
| mclr_n | input | 1 | External reset pin, active low |
| bor_en | input | 1 | Brown-out detection enable, active high |
| pwrt_en_n | input | 1 | Power-up timer enable, active low |
| osc_mode | input | 3 | Oscillator mode code: 0 LP, 1 XT, 2 HS, 3 HSPLL, 4 to 7 non-crystal |
| clr_flags | input | 1 | Synchronous strobe that clears the cause flags |
| core_rst_n | output | 1 | Core reset, active low, registered |
| flag_por | output | 1 | Sticky power-on cause flag |
| flag_bor | output | 1 | Sticky brown-out cause flag |
| flag_ext | output | 1 | Sticky external-reset cause flag |

## Verification
The hardest case to reach is a brown-out that arrives partway through the power-up count. The restart can only be seen if the bench knows exactly how many RC edges remain. The bench drives `rc_clk` and `osc_clk` edge by edge from tasks, so it steps the sequence into the middle of the count. It then raises `bor_det` for longer than the qualification time and requires a full count again after recovery. A second hard case is the threshold itself: the bench applies a dip exactly one cycle short of qualifying and then a long one.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    SQ_INIT  = 3'd0,
    SQ_BROWN = 3'd1,
    SQ_PWRUP = 3'd2,
    SQ_OSCST = 3'd3,
    SQ_PLLWT = 3'd4,
    SQ_RUN   = 3'd5
  } sq_state_t;

  localparam logic [2:0] MODE_PLL = 3'd3;

  // crystal-type modes occupy codes 0..3
  function automatic logic mode_is_crystal(input logic [2:0] m);
    return (m[2] == 1'b0);
  endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;
  logic s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/rsq_edge.sv
module rsq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk,
  output logic tick
);
  logic lvl;
  logic lvl_d;

  rsq_sync #(.RST_VAL(1'b0)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (slow_clk),
    .q     (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign tick = lvl & ~lvl_d;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
endmodule

// File: rtl/rsq_count.sv
module rsq_count #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          at_last;

  assign at_last = (cnt == LAST);

  always_comb begin
    cnt_nxt = cnt;
    if (!run)          cnt_nxt = '0;
    else if (tick)     cnt_nxt = at_last ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign done = run & tick & at_last;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt)); // R3
endmodule

// File: rtl/rsq_bor_qual.sv
module rsq_bor_qual #(
  parameter int QUAL = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic det_s,
  output logic hit
);
  localparam int QW = $clog2(QUAL + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL);

  logic [QW-1:0] run_len;
  logic [QW-1:0] run_len_nxt;

  always_comb begin
    run_len_nxt = run_len;
    if (!(enable && det_s))  run_len_nxt = '0;
    else if (run_len != QMAX) run_len_nxt = run_len + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= run_len_nxt;
  end

  assign hit = (run_len == QMAX);

  AST_BOR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(det_s) && $past(enable)); // R6
endmodule

// File: rtl/reset_timeout_seq.sv
module reset_timeout_seq
  import rsq_pkg::*;
#(
  parameter int PWRT_W     = 11,
  parameter int OST_CYCLES = 1024,
  parameter int PLL_TICKS  = 64,
  parameter int BOR_QUAL   = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rc_clk,
  input  logic       osc_clk,
  input  logic       bor_det,
  input  logic       mclr_n,
  input  logic       bor_en,
  input  logic       pwrt_en_n,
  input  logic [2:0] osc_mode,
  input  logic       clr_flags,
  output logic       core_rst_n,
  output logic       flag_por,
  output logic       flag_bor,
  output logic       flag_ext
);
  localparam int PWRT_TICKS = 2 ** PWRT_W;

  // reset synchroniser: asynchronous assert, synchronous release
  logic [1:0] rsync;
  logic       rst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_n = rsync[1];

  logic mclr_s;
  logic bor_s;
  logic rc_tick;
  logic osc_tick;
  logic bor_hit;

  rsq_sync #(.RST_VAL(1'b1)) u_mclr_sync (
    .clk (clk), .rst_n (rst_n), .d (mclr_n), .q (mclr_s));
  rsq_sync #(.RST_VAL(1'b0)) u_bor_sync (
    .clk (clk), .rst_n (rst_n), .d (bor_det), .q (bor_s));

  rsq_edge u_rc_edge (
    .clk (clk), .rst_n (rst_n), .slow_clk (rc_clk), .tick (rc_tick));
  rsq_edge u_osc_edge (
    .clk (clk), .rst_n (rst_n), .slow_clk (osc_clk), .tick (osc_tick));

  rsq_bor_qual #(.QUAL(BOR_QUAL)) u_bor_qual (
    .clk (clk), .rst_n (rst_n), .enable (bor_en), .det_s (bor_s), .hit (bor_hit));

  sq_state_t state;
  sq_state_t state_nxt;
  logic      from_por;
  logic      from_por_nxt;
  logic      pwrt_done;
  logic      ost_done;
  logic      pll_done;
  logic      pwrt_on;
  logic      crystal;
  logic      pll_mode;

  assign pwrt_on  = ~pwrt_en_n;
  assign crystal  = mode_is_crystal(osc_mode);
  assign pll_mode = (osc_mode == MODE_PLL);

  rsq_count #(.LIMIT(PWRT_TICKS)) u_pwrt_cnt (
    .clk (clk), .rst_n (rst_n), .run (state == SQ_PWRUP),
    .tick (rc_tick), .done (pwrt_done));
  rsq_count #(.LIMIT(OST_CYCLES)) u_ost_cnt (
    .clk (clk), .rst_n (rst_n), .run (state == SQ_OSCST),
    .tick (osc_tick), .done (ost_done));
  rsq_count #(.LIMIT(PLL_TICKS)) u_pll_cnt (
    .clk (clk), .rst_n (rst_n), .run (state == SQ_PLLWT),
    .tick (rc_tick), .done (pll_done));

  // where the chain goes once the power-up timer stage is over or skipped
  sq_state_t after_pwrt;
  always_comb begin
    if (from_por && crystal) after_pwrt = SQ_OSCST;
    else                     after_pwrt = SQ_RUN;
  end

  always_comb begin
    state_nxt = state;
    unique case (state)
      SQ_INIT:  state_nxt = pwrt_on ? SQ_PWRUP : after_pwrt;
      SQ_BROWN: state_nxt = pwrt_on ? SQ_PWRUP : SQ_RUN;
      SQ_PWRUP: if (pwrt_done) state_nxt = after_pwrt;
      SQ_OSCST: if (ost_done)  state_nxt = pll_mode ? SQ_PLLWT : SQ_RUN;
      SQ_PLLWT: if (pll_done)  state_nxt = SQ_RUN;
      SQ_RUN:   state_nxt = SQ_RUN;
      default:  state_nxt = SQ_INIT;
    endcase
    if (bor_hit) state_nxt = SQ_BROWN;
  end

  assign from_por_nxt = (state_nxt == SQ_BROWN) ? 1'b0 : from_por;

  logic rel_nxt;
  logic fpor_nxt;
  logic fbor_nxt;
  logic fext_nxt;

  always_comb begin
    rel_nxt  = (state_nxt == SQ_RUN) && mclr_s;
    fpor_nxt = flag_por & ~clr_flags;
    fbor_nxt = bor_hit | (flag_bor & ~clr_flags);
    fext_nxt = ~mclr_s | (flag_ext & ~clr_flags);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_INIT;
      from_por   <= 1'b1;
      core_rst_n <= 1'b0;
      flag_por   <= 1'b1;
      flag_bor   <= 1'b0;
      flag_ext   <= 1'b0;
    end else begin
      state      <= state_nxt;
      from_por   <= from_por_nxt;
      core_rst_n <= rel_nxt;
      flag_por   <= fpor_nxt;
      flag_bor   <= fbor_nxt;
      flag_ext   <= fext_nxt;
    end
  end

  AST_BOR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bor_hit |=> !core_rst_n); // R6
  AST_OST_CRYSTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_OSCST) |-> (osc_mode[2] == 1'b0)); // R3
  AST_PLL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_PLLWT) |-> (osc_mode == MODE_PLL)); // R4
  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mclr_s |=> !core_rst_n); // R8
  AST_POR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_por) |-> $past(clr_flags)); // R9
  AST_BROWN_NOT_POR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_BROWN) |=> !from_por); // R7
endmodule

// File: tb/sim_reset_timeout_seq.sv
`timescale 1ns/1ps
module sim_reset_timeout_seq;
  localparam int PW   = 4;
  localparam int NPW  = 2 ** PW;
  localparam int NOST = 8;
  localparam int NPLL = 4;
  localparam int NQ   = 4;

  logic       clk = 1'b0;
  logic       por_n, rc_clk, osc_clk, bor_det, mclr_n, bor_en, pwrt_en_n, clr_flags;
  logic [2:0] osc_mode;
  logic       core_rst_n, flag_por, flag_bor, flag_ext;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  reset_timeout_seq #(
    .PWRT_W(PW), .OST_CYCLES(NOST), .PLL_TICKS(NPLL), .BOR_QUAL(NQ)
  ) u0 (
    .clk(clk), .por_n(por_n), .rc_clk(rc_clk), .osc_clk(osc_clk),
    .bor_det(bor_det), .mclr_n(mclr_n), .bor_en(bor_en), .pwrt_en_n(pwrt_en_n),
    .osc_mode(osc_mode), .clr_flags(clr_flags), .core_rst_n(core_rst_n),
    .flag_por(flag_por), .flag_bor(flag_bor), .flag_ext(flag_ext));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic got, input logic exp, input string what);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  task automatic rc_pulse();
    rc_clk = 1'b1; step(4);
    rc_clk = 1'b0; step(4);
  endtask

  task automatic osc_pulse();
    osc_clk = 1'b1; step(4);
    osc_clk = 1'b0; step(4);
  endtask

  task automatic power_on(input logic [2:0] mode, input logic pen_n, input logic ben);
    por_n = 1'b0;
    step(2);
    osc_mode  = mode;
    pwrt_en_n = pen_n;
    bor_en    = ben;
    step(1);
    chk(core_rst_n, 1'b0, "R1 core held during power-on pulse");
    por_n = 1'b1;
    step(1);
  endtask

  // walk a run of RC edges; core must stay held before each one
  task automatic rc_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(core_rst_n, 1'b0, tag);
      rc_pulse();
    end
  endtask

  task automatic bor_pulse(input int len);
    bor_det = 1'b1; step(len);
    bor_det = 1'b0; step(6);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rc_clk = 1'b0; osc_clk = 1'b0; bor_det = 1'b0; mclr_n = 1'b1;
    bor_en = 1'b0; pwrt_en_n = 1'b0; clr_flags = 1'b0; osc_mode = 3'd4;
    step(3);

    // sweep every mode code with the timer on and off
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 2; p++) begin
        int e_pw, e_ost, e_pll;
        e_pw  = (p == 0) ? NPW : 0;
        e_ost = (m < 4) ? NOST : 0;
        e_pll = (m == 3) ? NPLL : 0;
        power_on(3'(m), p[0], 1'b0);
        chk(flag_por, 1'b1, "R1 power-on flag after reset");
        chk(flag_bor, 1'b0, "R1 brown-out flag after reset");
        chk(flag_ext, 1'b0, "R1 external flag after reset");
        if (e_pw > 0 && e_ost > 0) begin
          osc_pulse(); osc_pulse(); osc_pulse();   // R3: must not count
        end
        rc_run(e_pw, "R2 held during power-up count");
        for (int i = 0; i < e_ost; i++) begin
          chk(core_rst_n, 1'b0, "R3 held during oscillator count");
          osc_pulse();
        end
        rc_run(e_pll, "R4 held during PLL wait");
        step(4);
        if (e_pw + e_ost + e_pll == 0)
          chk(core_rst_n, 1'b1, "R5 no-delay release");
        else
          chk(core_rst_n, 1'b1, "R2 R3 R4 release after full chain");
      end
    end

    // brown-out qualification and recovery, non-crystal mode
    power_on(3'd4, 1'b0, 1'b1);
    rc_run(NPW, "R2 held during power-up count");
    step(4);
    chk(core_rst_n, 1'b1, "R2 released before brown-out tests");
    bor_pulse(NQ - 1);
    chk(core_rst_n, 1'b1, "R6 short dip ignored");
    chk(flag_bor, 1'b0, "R6 short dip leaves flag clear");
    bor_det = 1'b1; step(NQ + 4);
    chk(core_rst_n, 1'b0, "R6 qualified brown-out resets core");
    chk(flag_bor, 1'b1, "R6 brown-out flag set");
    rc_run(NPW + 4, "R6 held while brown-out present");
    bor_det = 1'b0; step(6);
    rc_run(NPW, "R7 power-up count reruns after brown-out");
    step(4);
    chk(core_rst_n, 1'b1, "R7 release after rerun");
    // brown-out in the middle of the count restarts it
    bor_pulse(NQ + 2);
    rc_run(NPW / 2, "R7 held in first half");
    bor_pulse(NQ + 2);
    rc_run(NPW, "R7 count restarted from zero");
    step(4);
    chk(core_rst_n, 1'b1, "R7 release after restarted count");
    // detection disabled
    bor_en = 1'b0;
    bor_pulse(NQ * 3);
    chk(core_rst_n, 1'b1, "R6 brown-out ignored when disabled");
    chk(flag_bor, 1'b1, "R9 brown-out flag still sticky");
    clr_flags = 1'b1; step(1); clr_flags = 1'b0; step(1);
    chk(flag_bor, 1'b0, "R9 clear strobe clears brown-out flag");
    chk(flag_por, 1'b0, "R9 clear strobe clears power-on flag");
    power_on(3'd4, 1'b0, 1'b1);
    chk(flag_por, 1'b1, "R9 power-on sets flag again");
    chk(flag_bor, 1'b0, "R9 power-on clears brown-out flag");

    // brown-out recovery in a crystal mode skips the oscillator stages
    power_on(3'd3, 1'b0, 1'b1);
    rc_run(NPW, "R2 held during power-up count");
    for (int i = 0; i < NOST; i++) osc_pulse();
    rc_run(NPLL, "R4 held during PLL wait");
    step(4);
    chk(core_rst_n, 1'b1, "R4 PLL-mode release");
    bor_pulse(NQ + 2);
    rc_run(NPW, "R7 power-up count only after brown-out");
    step(4);
    chk(core_rst_n, 1'b1, "R7 no oscillator stages after brown-out");

    // external pin held low across the whole chain
    mclr_n = 1'b0;
    power_on(3'd1, 1'b0, 1'b0);
    rc_run(NPW, "R8 held by pin during power-up count");
    for (int i = 0; i < NOST; i++) osc_pulse();
    step(8);
    chk(core_rst_n, 1'b0, "R8 pin keeps core held after delays");
    chk(flag_ext, 1'b1, "R8 external flag set");
    mclr_n = 1'b1; step(4);
    chk(core_rst_n, 1'b1, "R8 immediate release on pin rise");
    clr_flags = 1'b1; step(1); clr_flags = 1'b0; step(1);
    chk(flag_ext, 1'b0, "R9 clear strobe clears external flag");
    mclr_n = 1'b0; step(4);
    chk(core_rst_n, 1'b0, "R8 pin reset while running");
    chk(flag_ext, 1'b1, "R8 external flag set again");
    mclr_n = 1'b1; step(4);
    chk(core_rst_n, 1'b1, "R8 release without rerunning delays");
    step(40);
    chk(flag_ext, 1'b1, "R9 external flag stays set");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule